// File: doc/BRIEF.md
# Serial Management Register Slave

This block is the management end of a PHY. It runs on the management clock and watches the management data line. It hunts for a preamble of ones and then decodes clause-22 read and write frames. Frames that carry its own strapped PHY address are acted on, and all others are skipped. When the address matches, an active-low select output goes low. Read data is driven back through a registered output with its own enable, so that a pad or a bench can build the shared open line from the pair.

Two registers can be reached. The control word drives the side-effect outputs: a reset pulse, loopback together with an active-low loopback pin, power down, isolate, full duplex and collision test. A strap input decides whether isolate comes up set. The status word reports two fixed capability bits and a link bit. The link bit latches low on any link loss and stays low until software reads the status word.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is acted on only when at least PRE_LEN (default 32) consecutive ones, each sampled on a rising edge of `mdc`, come immediately before its start bits 0,1. A frame whose preamble is shorter causes no write and no drive.
- R2: The two bits after the start bits select the operation, read when they are 1,0 and write when they are 0,1. Any other pair abandons the frame with no effect. After them come the PHY address and then the register address, each 5 bits with the MSB first.
- R3: On a matched read the slave leaves the first turnaround bit undriven and drives 0 on the second. It then drives the 16 data bits with bit 15 first, and releases the line in the bit period that follows the data.
- R4: After the last PHY address bit, `sel_n` is low when the address equals `phy_addr` and returns high once the frame ends. A frame with a different address never drives `mdio_oe` and writes nothing.
- R5: Register address 0 is the control word. Bit 14 is loopback, bit 11 power down, bit 10 isolate, bit 8 full duplex and bit 7 collision test. Bit 13 always reads 1 and every other bit reads 0. Writes to read-only bits have no effect. Each writable bit appears on its own `ctl_*` output, and `loop_n` is the inverse of bit 14.
- R6: Writing 1 to control bit 15 returns every writable control bit to its default, whatever the other written bits hold. `ctl_reset` and control bit 15 are then 1 for exactly RST_HOLD `mdc` cycles after the write, and then clear.
- R7: The default of the isolate bit is the inverse of `strap_local`. It is applied by both `rst` and the control reset bit.
- R8: Register address 1 is the status word. It reads 1 in bits 14 and 13, the link latch in bit 2, and 0 in every other bit. Writes to it have no effect.
- R9: The link latch is 0 after reset and is cleared in any cycle in which `link_ok` is low. A status read returns the latched value and then reloads the latch with the current `link_ok`.
- R10: Register addresses 2 to 31 read as all zeros with the normal turnaround, and writes to them change nothing.
- R11: A high `rst`, sampled on a rising edge of `mdc`, returns both registers to their defaults and abandons any frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| phy_addr | input | ADR_W | Strapped PHY address of this slave |
| strap_local | input | 1 | Strap; low makes isolate default to 1 |
| link_ok | input | 1 | Live link state, high when the link is up |
| mdio_in | input | 1 | Sampled management data line |
| mdio_out | output | 1 | Data the slave drives onto the line |
| mdio_oe | output | 1 | Drive enable for `mdio_out` |
| sel_n | output | 1 | Low while a frame carries a matching PHY address |
| loop_n | output | 1 | Active-low loopback pin |
| ctl_reset | output | 1 | High while the control reset bit is in effect |
| ctl_loopback | output | 1 | Loopback control bit |
| ctl_pwrdn | output | 1 | Power-down control bit |
| ctl_isolate | output | 1 | Isolate control bit |
| ctl_fdx | output | 1 | Full-duplex control bit |
| ctl_coltest | output | 1 | Collision-test control bit |

## Verification
The assertions take the following for granted. `strap_local` is steady while a control reset is in effect. `link_ok`, `mdio_in` and the straps change only away from the rising edge of `mdc`. The master never starts a new frame while a control reset is still counting down. The bench changes every input on the falling edge. It holds the strap fixed between resets, and after each write it lets at least a full preamble go by before the next frame starts, so the RST_HOLD window has always closed. The stimulus covers all 32 combinations of the writable control bits, every foreign PHY address, every unused register address, both illegal operation codes, and a preamble one bit short.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;

   // Register word width of the management frame
   localparam int DAT_W = 16;

   // Operation codes as they appear on the line (first bit in [1])
   localparam logic [1:0] OP_RD = 2'b10;
   localparam logic [1:0] OP_WR = 2'b01;

   // Control word layout
   localparam int C_RST  = 15;
   localparam int C_LPBK = 14;
   localparam int C_SPD  = 13;
   localparam int C_PWD  = 11;
   localparam int C_ISO  = 10;
   localparam int C_FDX  = 8;
   localparam int C_COLT = 7;

   // Status word layout
   localparam int S_FDX_ABLE = 14;
   localparam int S_HDX_ABLE = 13;
   localparam int S_LINK     = 2;

   // Writable control bits and the constant part of the control word
   localparam logic [DAT_W-1:0] CTRL_WMASK =
      (DAT_W'(1) << C_LPBK) | (DAT_W'(1) << C_PWD) | (DAT_W'(1) << C_ISO) |
      (DAT_W'(1) << C_FDX)  | (DAT_W'(1) << C_COLT);
   localparam logic [DAT_W-1:0] CTRL_FIXED = DAT_W'(1) << C_SPD;
   localparam logic [DAT_W-1:0] STAT_FIXED =
      (DAT_W'(1) << S_FDX_ABLE) | (DAT_W'(1) << S_HDX_ABLE);

   typedef enum logic [2:0] {
      FS_HUNT,
      FS_ST1,
      FS_OP,
      FS_PHY,
      FS_REG,
      FS_TA,
      FS_DATA
   } frame_st_t;

endpackage

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
   import mdio_slv_pkg::*;
#(
   parameter int PRE_LEN = 32,
   parameter int ADR_W   = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [ADR_W-1:0] phy_addr,
   input  logic             mdio_in,
   input  logic [DAT_W-1:0] rd_data,
   output logic             mdio_out,
   output logic             mdio_oe,
   output logic             sel_n,
   output logic [ADR_W-1:0] reg_addr,
   output logic             rd_stb,
   output logic             wr_stb,
   output logic [DAT_W-1:0] wr_data
);

   localparam int PW = $clog2(PRE_LEN + 1);
   localparam int CW = $clog2(DAT_W);
   localparam logic [PW-1:0] PRE_FULL = PW'(PRE_LEN);
   localparam logic [CW-1:0] ADR_LAST = CW'(ADR_W - 1);
   localparam logic [CW-1:0] DAT_LAST = CW'(DAT_W - 1);

   generate
      if (PRE_LEN < 1) begin : g_bad_pre
         $error("PRE_LEN must be at least 1");
      end
      if (ADR_W < 2 || ADR_W > DAT_W) begin : g_bad_adr
         $error("ADR_W must lie between 2 and the data width");
      end
   endgenerate

   frame_st_t        st;
   logic [PW-1:0]    pre_cnt;
   logic [CW-1:0]    cnt;
   logic [DAT_W-1:0] sh;
   logic [DAT_W-1:0] sh_next;
   logic [DAT_W-1:0] rd_sh;
   logic             is_rd;
   logic             match;

   assign sh_next = {sh[DAT_W-2:0], mdio_in};

   always_ff @(posedge clk) begin
      if (rst) begin
         st       <= FS_HUNT;
         pre_cnt  <= '0;
         cnt      <= '0;
         sh       <= '0;
         rd_sh    <= '0;
         is_rd    <= 1'b0;
         match    <= 1'b0;
         reg_addr <= '0;
         mdio_oe  <= 1'b0;
         mdio_out <= 1'b0;
      end else begin
         unique case (st)
            FS_HUNT: begin
               if (mdio_in) begin
                  if (pre_cnt != PRE_FULL) pre_cnt <= pre_cnt + 1'b1;
               end else if (pre_cnt == PRE_FULL) begin
                  st <= FS_ST1;
               end else begin
                  pre_cnt <= '0;
               end
            end
            FS_ST1: begin
               pre_cnt <= '0;
               cnt     <= '0;
               st      <= mdio_in ? FS_OP : FS_HUNT;
            end
            FS_OP: begin
               sh <= sh_next;
               if (cnt == CW'(1)) begin
                  cnt <= '0;
                  if (sh_next[1:0] == OP_RD) begin
                     is_rd <= 1'b1;
                     st    <= FS_PHY;
                  end else if (sh_next[1:0] == OP_WR) begin
                     is_rd <= 1'b0;
                     st    <= FS_PHY;
                  end else begin
                     st <= FS_HUNT;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            FS_PHY: begin
               sh <= sh_next;
               if (cnt == ADR_LAST) begin
                  cnt   <= '0;
                  match <= (sh_next[ADR_W-1:0] == phy_addr);
                  st    <= FS_REG;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            FS_REG: begin
               sh <= sh_next;
               if (cnt == ADR_LAST) begin
                  cnt      <= '0;
                  reg_addr <= sh_next[ADR_W-1:0];
                  st       <= FS_TA;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            FS_TA: begin
               if (cnt == '0) begin
                  cnt <= CW'(1);
                  if (match && is_rd) begin
                     mdio_oe  <= 1'b1;
                     mdio_out <= 1'b0;
                     rd_sh    <= rd_data;
                  end
               end else begin
                  cnt <= '0;
                  st  <= FS_DATA;
                  if (mdio_oe) begin
                     mdio_out <= rd_sh[DAT_W-1];
                     rd_sh    <= {rd_sh[DAT_W-2:0], 1'b0};
                  end
               end
            end
            FS_DATA: begin
               sh <= sh_next;
               if (mdio_oe) begin
                  mdio_out <= rd_sh[DAT_W-1];
                  rd_sh    <= {rd_sh[DAT_W-2:0], 1'b0};
               end
               if (cnt == DAT_LAST) begin
                  cnt      <= '0;
                  mdio_oe  <= 1'b0;
                  mdio_out <= 1'b0;
                  match    <= 1'b0;
                  pre_cnt  <= '0;
                  st       <= FS_HUNT;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= FS_HUNT;
         endcase
      end
   end

   assign sel_n   = !match;
   assign rd_stb  = (st == FS_TA) && (cnt == '0) && match && is_rd;
   assign wr_stb  = (st == FS_DATA) && (cnt == DAT_LAST) && match && !is_rd;
   assign wr_data = sh_next;

   // R3: the first driven turnaround bit is a zero
   p_ta_zero_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(mdio_oe) |-> !mdio_out);

   // R3: the line is released right after the last data bit
   p_release_r3: assert property (@(posedge clk) disable iff (rst)
      (st == FS_DATA && cnt == DAT_LAST) |=> !mdio_oe);

   // R4: the slave only drives inside a frame that matched its address
   p_drive_sel_r4: assert property (@(posedge clk) disable iff (rst)
      mdio_oe |-> !sel_n);

   // R1: a frame can only begin from a full preamble
   p_pre_full_r1: assert property (@(posedge clk) disable iff (rst)
      (st == FS_HUNT && !mdio_in && pre_cnt != PRE_FULL) |=> (st == FS_HUNT));

endmodule

// File: rtl/mdio_ctrl_reg.sv
module mdio_ctrl_reg
   import mdio_slv_pkg::*;
#(
   parameter int RST_HOLD = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             strap_local,
   input  logic             wr_stb,
   input  logic [DAT_W-1:0] wr_data,
   output logic [DAT_W-1:0] value,
   output logic             ctl_reset,
   output logic             ctl_loopback,
   output logic             ctl_pwrdn,
   output logic             ctl_isolate,
   output logic             ctl_fdx,
   output logic             ctl_coltest
);

   localparam int HW = $clog2(RST_HOLD + 1);

   generate
      if (RST_HOLD < 1) begin : g_bad_hold
         $error("RST_HOLD must be at least 1");
      end
   endgenerate

   logic [HW-1:0]    hold_cnt;
   logic [DAT_W-1:0] ctrl_q;
   logic [DAT_W-1:0] dflt;

   assign dflt = CTRL_FIXED | (DAT_W'(!strap_local) << C_ISO);

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_cnt <= '0;
         ctrl_q   <= dflt;
      end else if (hold_cnt != '0) begin
         hold_cnt <= hold_cnt - 1'b1;
      end else if (wr_stb) begin
         if (wr_data[C_RST]) begin
            hold_cnt <= HW'(RST_HOLD);
            ctrl_q   <= dflt;
         end else begin
            ctrl_q <= (wr_data & CTRL_WMASK) | CTRL_FIXED;
         end
      end
   end

   assign ctl_reset    = (hold_cnt != '0);
   assign value        = ctrl_q | (DAT_W'(ctl_reset) << C_RST);
   assign ctl_loopback = ctrl_q[C_LPBK];
   assign ctl_pwrdn    = ctrl_q[C_PWD];
   assign ctl_isolate  = ctrl_q[C_ISO];
   assign ctl_fdx      = ctrl_q[C_FDX];
   assign ctl_coltest  = ctrl_q[C_COLT];

   // R6: while the reset bit is in effect every writable bit sits at its default
   p_rst_dflt_r6: assert property (@(posedge clk) disable iff (rst)
      ctl_reset |-> !ctl_loopback && !ctl_pwrdn && !ctl_fdx && !ctl_coltest);

   // R6: a reset request raises the reset output on the next cycle
   p_rst_start_r6: assert property (@(posedge clk) disable iff (rst)
      (wr_stb && wr_data[C_RST] && !ctl_reset) |=> ctl_reset);

   // R5: the speed bit never leaves 1
   p_speed_r5: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> value[C_SPD]);

endmodule

// File: rtl/mdio_stat_reg.sv
module mdio_stat_reg
   import mdio_slv_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             link_ok,
   input  logic             rd_stb,
   output logic [DAT_W-1:0] value
);

   logic link_lat;

   always_ff @(posedge clk) begin
      if (rst)         link_lat <= 1'b0;
      else if (rd_stb) link_lat <= link_ok;
      else             link_lat <= link_lat & link_ok;
   end

   assign value = STAT_FIXED | (DAT_W'(link_lat) << S_LINK);

   // R9: a link loss always clears the latch
   p_link_drop_r9: assert property (@(posedge clk) disable iff (rst)
      !link_ok |=> !link_lat);

   // R9: a cleared latch stays cleared until a status read
   p_link_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (!link_lat && !rd_stb) |=> !link_lat);

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
   import mdio_slv_pkg::*;
#(
   parameter int PRE_LEN  = 32,
   parameter int ADR_W    = 5,
   parameter int RST_HOLD = 4
) (
   input  logic             mdc,
   input  logic             rst,
   input  logic [ADR_W-1:0] phy_addr,
   input  logic             strap_local,
   input  logic             link_ok,
   input  logic             mdio_in,
   output logic             mdio_out,
   output logic             mdio_oe,
   output logic             sel_n,
   output logic             loop_n,
   output logic             ctl_reset,
   output logic             ctl_loopback,
   output logic             ctl_pwrdn,
   output logic             ctl_isolate,
   output logic             ctl_fdx,
   output logic             ctl_coltest
);

   localparam logic [ADR_W-1:0] A_CTRL = ADR_W'(0);
   localparam logic [ADR_W-1:0] A_STAT = ADR_W'(1);

   logic [ADR_W-1:0] reg_addr;
   logic             rd_stb;
   logic             wr_stb;
   logic [DAT_W-1:0] wr_data;
   logic [DAT_W-1:0] rd_data;
   logic [DAT_W-1:0] ctrl_val;
   logic [DAT_W-1:0] stat_val;
   logic             ctrl_wr;
   logic             stat_rd;

   mdio_frame_engine #(
      .PRE_LEN (PRE_LEN),
      .ADR_W   (ADR_W)
   ) u_engine (
      .clk      (mdc),
      .rst      (rst),
      .phy_addr (phy_addr),
      .mdio_in  (mdio_in),
      .rd_data  (rd_data),
      .mdio_out (mdio_out),
      .mdio_oe  (mdio_oe),
      .sel_n    (sel_n),
      .reg_addr (reg_addr),
      .rd_stb   (rd_stb),
      .wr_stb   (wr_stb),
      .wr_data  (wr_data)
   );

   assign ctrl_wr = wr_stb && (reg_addr == A_CTRL);
   assign stat_rd = rd_stb && (reg_addr == A_STAT);

   mdio_ctrl_reg #(
      .RST_HOLD (RST_HOLD)
   ) u_ctrl (
      .clk          (mdc),
      .rst          (rst),
      .strap_local  (strap_local),
      .wr_stb       (ctrl_wr),
      .wr_data      (wr_data),
      .value        (ctrl_val),
      .ctl_reset    (ctl_reset),
      .ctl_loopback (ctl_loopback),
      .ctl_pwrdn    (ctl_pwrdn),
      .ctl_isolate  (ctl_isolate),
      .ctl_fdx      (ctl_fdx),
      .ctl_coltest  (ctl_coltest)
   );

   mdio_stat_reg u_stat (
      .clk     (mdc),
      .rst     (rst),
      .link_ok (link_ok),
      .rd_stb  (stat_rd),
      .value   (stat_val)
   );

   always_comb begin
      unique case (reg_addr)
         A_CTRL:  rd_data = ctrl_val;
         A_STAT:  rd_data = stat_val;
         default: rd_data = '0;
      endcase
   end

   assign loop_n = !ctl_loopback;

   // R5: the loopback pin is low exactly while loopback is set
   p_loop_pin_r5: assert property (@(posedge mdc) disable iff (rst)
      $rose(ctl_loopback) |-> !loop_n);

   // R11: reset leaves the line undriven and deselected
   p_rst_idle_r11: assert property (@(posedge mdc)
      rst |=> !mdio_oe && sel_n && !ctl_reset);

endmodule

// File: tb/test_mdio_mgmt_slave.sv
`timescale 1ns/100ps
module test_mdio_mgmt_slave;

   localparam int PRE_LEN  = 32;
   localparam int RST_HOLD = 4;
   localparam logic [4:0] OWN = 5'h0B;

   logic mdc = 1'b0;
   logic rst = 1'b1;
   logic [4:0] phy_addr = OWN;
   logic strap_local = 1'b1;
   logic link_ok = 1'b1;
   logic mdio_in = 1'b1;
   logic mdio_out, mdio_oe, sel_n, loop_n;
   logic ctl_reset, ctl_loopback, ctl_pwrdn, ctl_isolate, ctl_fdx, ctl_coltest;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 mdc = ~mdc;

   mdio_mgmt_slave #(
      .PRE_LEN (PRE_LEN),
      .ADR_W   (5),
      .RST_HOLD(RST_HOLD)
   ) i_mdio_mgmt_slave (
      .mdc, .rst, .phy_addr, .strap_local, .link_ok, .mdio_in,
      .mdio_out, .mdio_oe, .sel_n, .loop_n, .ctl_reset, .ctl_loopback,
      .ctl_pwrdn, .ctl_isolate, .ctl_fdx, .ctl_coltest
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one bit period: sample outputs valid for this bit, then drive the bit
   task automatic slot(input logic b, output logic o, output logic d, output logic s);
      @(negedge mdc);
      o = mdio_oe; d = mdio_out; s = sel_n;
      mdio_in = b;
   endtask

   task automatic run_frame(input int npre, input logic [1:0] op, input logic [4:0] pa,
                            input logic [4:0] ra, input logic [15:0] wd,
                            output logic [15:0] rd, output logic drv_ok,
                            output logic sel_lo, output logic any_oe);
      logic o, d, s;
      rd = '0; drv_ok = 1'b1; sel_lo = 1'b0; any_oe = 1'b0;
      for (int i = 0; i < npre; i++) begin slot(1'b1, o, d, s); any_oe |= o; end
      slot(1'b0, o, d, s); any_oe |= o;
      slot(1'b1, o, d, s); any_oe |= o;
      slot(op[1], o, d, s); any_oe |= o;
      slot(op[0], o, d, s); any_oe |= o;
      for (int i = 4; i >= 0; i--) begin slot(pa[i], o, d, s); any_oe |= o; end
      for (int i = 4; i >= 0; i--) begin slot(ra[i], o, d, s); any_oe |= o; end
      slot(1'b1, o, d, s); any_oe |= o; sel_lo = !s; if (o) drv_ok = 1'b0;
      slot(op == 2'b01 ? 1'b0 : 1'b1, o, d, s); any_oe |= o;
      if (!(o && !d)) drv_ok = 1'b0;
      for (int i = 15; i >= 0; i--) begin
         slot(op == 2'b01 ? wd[i] : 1'b1, o, d, s);
         any_oe |= o; rd[i] = d; if (!o) drv_ok = 1'b0;
      end
      slot(1'b1, o, d, s); any_oe |= o; if (o) drv_ok = 1'b0;
   endtask

   task automatic wr(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd);
      logic [15:0] r; logic k, s, a;
      run_frame(PRE_LEN, 2'b01, pa, ra, wd, r, k, s, a);
   endtask

   task automatic rd(input string req, input logic [4:0] ra, input logic [15:0] exp);
      logic [15:0] r; logic k, s, a;
      run_frame(PRE_LEN, 2'b10, OWN, ra, 16'h0, r, k, s, a);
      chk(req, r, exp);
      chk({req, " turnaround/release R3"}, k, 1'b1);
   endtask

   task automatic hw_reset(input logic loc);
      @(negedge mdc);
      strap_local = loc; rst = 1'b1; mdio_in = 1'b1;
      repeat (3) @(negedge mdc);
      rst = 1'b0;
   endtask

   function automatic logic [15:0] ctrl_exp(input logic [15:0] wd);
      return 16'h2000 | (wd & 16'h4D80);
   endfunction

   initial begin
      repeat (150000) @(posedge mdc);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] r, wd; logic k, s, a; int n;

      // R11 reset state, local strap high
      hw_reset(1'b1);
      @(negedge mdc);
      chk("R11 oe after reset", mdio_oe, 1'b0);
      chk("R11 sel_n after reset", sel_n, 1'b1);
      chk("R11 control outputs after reset",
          {ctl_reset, ctl_loopback, ctl_pwrdn, ctl_isolate, ctl_fdx, ctl_coltest, loop_n}, 7'b0000001);
      run_frame(PRE_LEN, 2'b10, OWN, 5'd0, 16'h0, r, k, s, a);
      chk("R7 control default local=1", r, 16'h2000);
      chk("R3 read drive pattern", k, 1'b1);
      chk("R4 sel_n low during matched frame", s, 1'b1);
      chk("R4 sel_n high after frame", sel_n, 1'b1);

      // R7 isolate default with local low
      hw_reset(1'b0);
      rd("R7 control default local=0", 5'd0, 16'h2400);
      chk("R7 isolate output", ctl_isolate, 1'b1);

      // R5 sweep over all writable combinations with junk in read-only bits
      for (int v = 0; v < 32; v++) begin
         wd = (16'(v & 1) << 14) | (16'((v >> 1) & 1) << 11) | (16'((v >> 2) & 1) << 10) |
              (16'((v >> 3) & 1) << 8) | (16'((v >> 4) & 1) << 7) |
              (16'(v * 16'h1111) & 16'h327F);
         wr(OWN, 5'd0, wd);
         chk("R5 outputs follow control",
             {ctl_loopback, ctl_pwrdn, ctl_isolate, ctl_fdx, ctl_coltest, loop_n, ctl_reset},
             {wd[14], wd[11], wd[10], wd[8], wd[7], !wd[14], 1'b0});
         rd("R5 control readback", 5'd0, ctrl_exp(wd));
      end

      // R4 foreign addresses: no drive, no write, no select
      wr(OWN, 5'd0, 16'h4100);
      for (int p = 0; p < 32; p++) begin
         if (5'(p) != OWN) begin
            wr(5'(p), 5'd0, 16'h0C80);
            run_frame(PRE_LEN, 2'b10, 5'(p), 5'd0, 16'h0, r, k, s, a);
            chk("R4 foreign read never drives", a, 1'b0);
            chk("R4 foreign frame keeps sel_n high", s, 1'b0);
         end
      end
      rd("R4 control unchanged by foreign writes", 5'd0, 16'h6100);

      // R10 unused addresses, R8 status ignores writes
      for (int ra = 2; ra < 32; ra++) begin
         wr(OWN, 5'(ra), 16'hFFFF);
         rd("R10 unused address reads zero", 5'(ra), 16'h0000);
      end
      rd("R10 control untouched", 5'd0, 16'h6100);
      wr(OWN, 5'd1, 16'h0000);
      wr(OWN, 5'd1, 16'hFFFF);
      rd("R8 status after writes (first read, latch from reset)", 5'd1, 16'h6000);
      rd("R8 status link up", 5'd1, 16'h6004);
      rd("R8 control untouched by status write", 5'd0, 16'h6100);

      // R1 short preamble
      begin
         logic o, d, s2;
         slot(1'b0, o, d, s2);
      end
      run_frame(PRE_LEN - 1, 2'b01, OWN, 5'd0, 16'h0880, r, k, s, a);
      rd("R1 short-preamble write ignored", 5'd0, 16'h6100);
      begin
         logic o, d, s2;
         slot(1'b0, o, d, s2);
      end
      run_frame(PRE_LEN - 1, 2'b10, OWN, 5'd0, 16'h0, r, k, s, a);
      chk("R1 short-preamble read never drives", a, 1'b0);

      // R2 illegal operation codes
      run_frame(PRE_LEN, 2'b00, OWN, 5'd0, 16'h0880, r, k, s, a);
      chk("R2 op 00 does not drive", a, 1'b0);
      run_frame(PRE_LEN, 2'b11, OWN, 5'd0, 16'h0880, r, k, s, a);
      chk("R2 op 11 does not drive", a, 1'b0);
      rd("R2 illegal ops leave control", 5'd0, 16'h6100);

      // R6 control reset bit, R7 default with local low
      wr(OWN, 5'd0, 16'h4D80);
      wr(OWN, 5'd0, 16'hCD80);
      chk("R6 reset output right after write", ctl_reset, 1'b1);
      chk("R6 fields default during reset (local=0)",
          {ctl_loopback, ctl_pwrdn, ctl_isolate, ctl_fdx, ctl_coltest}, 5'b00100);
      n = 0;
      while (ctl_reset && n < 100) begin @(negedge mdc); n++; end
      chk("R6 reset pulse length", n, RST_HOLD);
      rd("R7 control after bit-15 reset, local=0", 5'd0, 16'h2400);
      hw_reset(1'b1);
      wr(OWN, 5'd0, 16'h4D80);
      wr(OWN, 5'd0, 16'h8D80);
      n = 0;
      while (ctl_reset && n < 100) begin @(negedge mdc); n++; end
      chk("R6 reset pulse length again", n, RST_HOLD);
      rd("R6 control after bit-15 reset, local=1", 5'd0, 16'h2000);

      // R9 link latch
      hw_reset(1'b1);
      link_ok = 1'b1;
      rd("R9 first status read after reset", 5'd1, 16'h6000);
      rd("R9 reloaded link", 5'd1, 16'h6004);
      @(negedge mdc); link_ok = 1'b0;
      repeat (2) @(negedge mdc); link_ok = 1'b1;
      rd("R9 latched loss", 5'd1, 16'h6000);
      rd("R9 recovered after read", 5'd1, 16'h6004);
      @(negedge mdc); link_ok = 1'b0;
      rd("R9 read while down", 5'd1, 16'h6000);
      rd("R9 reload with live low", 5'd1, 16'h6000);
      @(negedge mdc); link_ok = 1'b1;
      rd("R9 still low before read", 5'd1, 16'h6000);
      rd("R9 up after read", 5'd1, 16'h6004);

      // R11 hardware reset clears written state
      wr(OWN, 5'd0, 16'h4D80);
      hw_reset(1'b1);
      @(negedge mdc);
      chk("R11 outputs after second reset",
          {ctl_loopback, ctl_pwrdn, ctl_isolate, ctl_fdx, ctl_coltest, loop_n}, 6'b000001);
      rd("R11 control after reset", 5'd0, 16'h2000);
      rd("R11 status latch after reset", 5'd1, 16'h6000);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule